// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address. It walks a two-level page table that is held in memory. A plain input supplies the frame number of the root table. A translation request enters through a valid/ready port. The walker then issues two dependent reads through a request/response memory port. The first read fetches the root-level entry, which names the frame of a leaf table. The second read fetches the leaf-level entry, which names the physical frame of the page. The result leaves through a second valid/ready port. It carries the physical frame, the untouched page offset and a fault flag.

Only one walk is in flight at a time. Back-pressure is honoured on every side:
- A request is taken only when `req_ready` is high. It stays low from acceptance until the result has been consumed.
- A memory read is held, with its address steady, until `mem_rd_ready` is seen high.
- A result is held, with all fields steady, until `rsp_ready` is seen high.

Either entry being invalid ends the walk with a fault.

Top module: `pt_walker`

## Requirements
- R1: `rsp_offset` equals bits 11:0 of the accepted virtual address, whether or not the walk faults.
- R2: The first memory read goes to address `{root_frame, 12'h000} + 4 * vaddr[31:22]`.
- R3: The second read goes to address `{root_entry[31:12], 12'h000} + 4 * vaddr[21:12]`. It is issued only after the first read's response has arrived. No read is requested while a response is outstanding.
- R4: When both entries have bit 0 set (valid), `rsp_fault` is 0 and `rsp_frame` equals bits 31:12 of the leaf entry.
- R5: When the leaf entry has bit 0 clear, `rsp_fault` is 1 and `rsp_frame` is zero.
- R6: When the root entry has bit 0 clear, `rsp_fault` is 1, `rsp_frame` is zero, and exactly one memory read is made for that walk.
- R7: `req_ready` is high only while idle. It drops the cycle after a request is accepted and returns only after the result has been accepted.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_frame`, `rsp_offset` and `rsp_fault` hold their values.
- R9: While `mem_rd_valid` is high and `mem_rd_ready` is low, `mem_rd_valid` and `mem_rd_addr` hold their values.
- R10: After reset, `req_ready` is 1 and `mem_rd_valid` and `rsp_valid` are 0.
- R11: A `mem_rsp_valid` pulse that arrives while no read is outstanding has no effect on the walk's reads or its result.
- R12: Every read address is aligned to 4 bytes (bits 1:0 are zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_frame | input | 20 | Frame number of the root table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry: bit 0 valid, bits 31:12 frame |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_frame | output | 20 | Physical frame, zero on fault |
| rsp_offset | output | 12 | Page offset copied from the virtual address |
| rsp_fault | output | 1 | Page fault indication |

## Verification
Two situations are hard to reach from the ports.

The first is a memory response arriving while the walker is still waiting for its read to be accepted. The bench produces it with a memory model that can inject stray response pulses on every third cycle. These pulses carry entries that look valid. The bench then checks that the read addresses and the result match a walk that never saw them.

The second is a long memory stall that overlaps a held read request. The model gates `mem_rd_ready` so that it accepts only on one cycle in four, and it adds response latency. This keeps requests pending over several edges, so the hold rule on the address can be checked on every stalled cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_L1_REQ  = 3'd1,
    ST_L1_WAIT = 3'd2,
    ST_L2_REQ  = 3'd3,
    ST_L2_WAIT = 3'd4,
    ST_DONE    = 3'd5
  } walk_state_e;

  localparam int unsigned NUM_LEVELS = 2;

endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic [VA_W-1:0]  vaddr,
  output logic [IDX_W-1:0] idx_root,
  output logic [IDX_W-1:0] idx_leaf,
  output logic [OFF_W-1:0] page_off
);
  localparam int unsigned LEAF_TOP = OFF_W + IDX_W - 1;

  assign idx_root = vaddr[VA_W-1 -: IDX_W];
  assign idx_leaf = vaddr[LEAF_TOP -: IDX_W];
  assign page_off = vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int unsigned FRAME_W   = 20,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned ENT_LG    = 2,
  localparam int unsigned AW       = FRAME_W + OFF_W
) (
  input  logic [FRAME_W-1:0] table_frame,
  input  logic [IDX_W-1:0]   index,
  output logic [AW-1:0]      entry_addr
);
  generate
    if (IDX_W + ENT_LG == OFF_W) begin : g_exact
      // table fills the page exactly: plain concatenation, no adder
      assign entry_addr = {table_frame, index, {ENT_LG{1'b0}}};
    end else begin : g_add
      assign entry_addr = {table_frame, {OFF_W{1'b0}}}
                        + AW'({index, {ENT_LG{1'b0}}});
    end
  endgenerate
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int unsigned PTE_W = 32,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned FRAME_W = PTE_W - OFF_W
) (
  input  logic [PTE_W-1:0]   entry,
  output logic               ent_valid,
  output logic [FRAME_W-1:0] ent_frame
);
  logic unused_flag_bits;

  assign ent_valid        = entry[0];
  assign ent_frame        = entry[PTE_W-1:OFF_W];
  assign unused_flag_bits = ^entry[OFF_W-1:1];
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic [VA_W-1:0]    vaddr_q,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic               lvl_sel,
  input  logic               mem_rsp_valid,
  input  logic               ent_valid,
  input  logic [FRAME_W-1:0] ent_frame,
  output logic [FRAME_W-1:0] leaf_tbl_q,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic               rsp_fault
);
  walk_state_e         state;
  logic [FRAME_W-1:0]  frame_q;
  logic                fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      vaddr_q    <= '0;
      leaf_tbl_q <= '0;
      frame_q    <= '0;
      fault_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          vaddr_q <= req_vaddr;
          frame_q <= '0;
          fault_q <= 1'b0;
          state   <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_rd_ready) state <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid) begin
          if (ent_valid) begin
            leaf_tbl_q <= ent_frame;
            state      <= ST_L2_REQ;
          end else begin
            fault_q <= 1'b1;
            frame_q <= '0;
            state   <= ST_DONE;
          end
        end
        ST_L2_REQ: if (mem_rd_ready) state <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid) begin
          fault_q <= ~ent_valid;
          frame_q <= ent_valid ? ent_frame : '0;
          state   <= ST_DONE;
        end
        ST_DONE: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign mem_rd_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign lvl_sel      = (state == ST_L2_REQ) || (state == ST_L2_WAIT);
  assign rsp_valid    = (state == ST_DONE);
  assign rsp_frame    = frame_q;
  assign rsp_fault    = fault_q;

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_phase_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_rd_valid, rsp_valid}));

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_frame) && $stable(rsp_fault)
                                && $stable(vaddr_q));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(lvl_sel));

  p_fault_zero_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_frame == '0);

  p_root_fault_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_L1_WAIT) && mem_rsp_valid && !ent_valid |=> !mem_rd_valid && rsp_valid);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned PTE_W  = 32,
  parameter int unsigned ENT_LG = 2,
  localparam int unsigned FRAME_W = PTE_W - OFF_W,
  localparam int unsigned PA_W    = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] root_frame,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [PA_W-1:0]    mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  logic [PTE_W-1:0]   mem_rsp_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic [OFF_W-1:0]   rsp_offset,
  output logic               rsp_fault
);
  localparam int unsigned LVLS = ptw_pkg::NUM_LEVELS;

  logic [VA_W-1:0]    vaddr_q;
  logic [IDX_W-1:0]   lvl_idx   [LVLS];
  logic [FRAME_W-1:0] lvl_tbl   [LVLS];
  logic [PA_W-1:0]    lvl_addr  [LVLS];
  logic [FRAME_W-1:0] leaf_tbl_q;
  logic               lvl_sel;
  logic               ent_valid;
  logic [FRAME_W-1:0] ent_frame;

  ptw_va_split #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
    .vaddr    (vaddr_q),
    .idx_root (lvl_idx[0]),
    .idx_leaf (lvl_idx[1]),
    .page_off (rsp_offset)
  );

  assign lvl_tbl[0] = root_frame;
  assign lvl_tbl[1] = leaf_tbl_q;

  generate
    for (genvar g = 0; g < LVLS; g++) begin : g_lvl
      ptw_entry_addr #(
        .FRAME_W(FRAME_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LG(ENT_LG)
      ) u_addr (
        .table_frame (lvl_tbl[g]),
        .index       (lvl_idx[g]),
        .entry_addr  (lvl_addr[g])
      );
    end
  endgenerate

  assign mem_rd_addr = lvl_sel ? lvl_addr[1] : lvl_addr[0];

  ptw_pte_decode #(.PTE_W(PTE_W), .OFF_W(OFF_W)) u_dec (
    .entry     (mem_rsp_data),
    .ent_valid (ent_valid),
    .ent_frame (ent_frame)
  );

  ptw_ctrl #(.VA_W(VA_W), .FRAME_W(FRAME_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .vaddr_q       (vaddr_q),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .lvl_sel       (lvl_sel),
    .mem_rsp_valid (mem_rsp_valid),
    .ent_valid     (ent_valid),
    .ent_frame     (ent_frame),
    .leaf_tbl_q    (leaf_tbl_q),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_frame     (rsp_frame),
    .rsp_fault     (rsp_fault)
  );

  p_rd_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> $stable(mem_rd_addr));

  p_rd_aligned_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> mem_rd_addr[ENT_LG-1:0] == '0);

  p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_offset == vaddr_q[OFF_W-1:0]);
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] root_frame = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b1;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [19:0] rsp_frame;
  logic [11:0] rsp_offset;
  logic        rsp_fault;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .root_frame(root_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_frame(rsp_frame),
    .rsp_offset(rsp_offset), .rsp_fault(rsp_fault)
  );

  // ---------------- memory model ----------------
  logic [31:0] pmem [logic [31:0]];
  int          lat = 0;
  bit          stall_en = 0;
  bit          spurious = 0;
  int          rd_count = 0;
  logic [31:0] rd_addr [4];
  bit          pend = 0;
  int          cnt = 0;
  logic [31:0] pend_addr = '0;
  bit          prev_stalled = 0;
  logic [31:0] prev_addr = '0;
  int          cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd_mem(pend_addr);
          pend = 0;
        end else cnt--;
      end else if (spurious && (cyc % 3 == 0)) begin
        mem_rsp_valid = 1'b1;        // stray response carrying a valid-looking entry
        mem_rsp_data  = 32'hFFFF_F001;
      end
      if (prev_stalled)
        chk(mem_rd_valid && mem_rd_addr == prev_addr, "R9", "held read",
            {31'b0, mem_rd_valid, mem_rd_addr}, {32'h1, prev_addr});
      if (pend && mem_rd_valid)
        chk(1'b0, "R3", "read while response outstanding", 1, 0);
      mem_rd_ready = stall_en ? (cyc % 4 == 0) : 1'b1;
      prev_stalled = mem_rd_valid && !mem_rd_ready;
      prev_addr    = mem_rd_addr;
      if (mem_rd_valid && mem_rd_ready) begin
        if (rd_count < 4) rd_addr[rd_count] = mem_rd_addr;
        rd_count++;
        pend = 1; cnt = lat; pend_addr = mem_rd_addr;
      end
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [31:0] ent_addr(input logic [19:0] tbl, input logic [9:0] idx);
    return {tbl, 12'h000} + {20'h0, idx, 2'b00};
  endfunction

  task automatic run_walk(input string name, input logic [31:0] va, input logic [19:0] leaf_tbl,
                          input bit exp_fault, input logic [19:0] exp_frame, input int exp_reads,
                          input int hold, input bit keep_req);
    int n;
    bit busy_bad;
    logic [19:0] f0; logic [11:0] o0; logic fl0;
    @(negedge clk);
    rd_count = 0;
    req_valid = 1'b1; req_vaddr = va;
    @(posedge clk); #1;
    chk(!req_ready, "R7", {name, " ready drops after accept"}, req_ready, 0);
    @(negedge clk);
    if (keep_req) req_vaddr = ~va; else req_valid = 1'b0;
    n = 0; busy_bad = 0;
    while (!rsp_valid && n < 500) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk); n++;
    end
    chk(rsp_valid, "R7", {name, " result arrives"}, rsp_valid, 1);
    chk(!busy_bad, "R7", {name, " ready low while busy"}, busy_bad, 0);
    chk(rsp_offset == va[11:0], "R1", {name, " offset"}, rsp_offset, va[11:0]);
    chk(rsp_fault == exp_fault, exp_fault ? "R5" : "R4", {name, " fault"}, rsp_fault, exp_fault);
    chk(rsp_frame == exp_frame, exp_fault ? "R5" : "R4", {name, " frame"}, rsp_frame, exp_frame);
    chk(rd_count == exp_reads, exp_reads == 1 ? "R6" : "R3", {name, " read count"}, rd_count, exp_reads);
    chk(rd_addr[0] == ent_addr(root_frame, va[31:22]), "R2", {name, " root read addr"},
        rd_addr[0], ent_addr(root_frame, va[31:22]));
    chk(rd_addr[0][1:0] == 2'b00, "R12", {name, " alignment"}, rd_addr[0][1:0], 0);
    if (exp_reads == 2)
      chk(rd_addr[1] == ent_addr(leaf_tbl, va[21:12]), "R3", {name, " leaf read addr"},
          rd_addr[1], ent_addr(leaf_tbl, va[21:12]));
    f0 = rsp_frame; o0 = rsp_offset; fl0 = rsp_fault;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_frame == f0 && rsp_offset == o0 && rsp_fault == fl0, "R8",
          {name, " result held"}, {rsp_valid, rsp_fault, rsp_frame}, {1'b1, fl0, f0});
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R7", {name, " idle after handoff"}, {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic map_page(input logic [31:0] va, input logic [19:0] leaf_tbl, input logic [19:0] frame,
                          input bit root_ok, input bit leaf_ok);
    pmem[ent_addr(root_frame, va[31:22])] = {leaf_tbl, 11'h0, root_ok};
    pmem[ent_addr(leaf_tbl, va[21:12])]   = {frame, 11'h2A5, leaf_ok};
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(req_ready === 1'b1, "R10", "reset req_ready", req_ready, 1);
    chk(mem_rd_valid === 1'b0, "R10", "reset mem_rd_valid", mem_rd_valid, 0);
    chk(rsp_valid === 1'b0, "R10", "reset rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_basic();   // R2 R3 R4 R1
    root_frame = 20'h00010;
    map_page(32'h0040_3ABC, 20'h00020, 20'h12345, 1, 1);
    run_walk("basic", 32'h0040_3ABC, 20'h00020, 0, 20'h12345, 2, 0, 0);
  endtask

  task automatic t_edges();   // highest and lowest indices, extreme offsets
    map_page(32'hFFFF_FFFF, 20'hABCDE, 20'hFEDCB, 1, 1);
    run_walk("top_idx", 32'hFFFF_FFFF, 20'hABCDE, 0, 20'hFEDCB, 2, 0, 0);
    root_frame = 20'h00300;
    map_page(32'h0000_0000, 20'h00001, 20'h00007, 1, 1);
    run_walk("zero_idx", 32'h0000_0000, 20'h00001, 0, 20'h00007, 2, 0, 0);
  endtask

  task automatic t_leaf_fault();   // R5
    root_frame = 20'h00010;
    map_page(32'h0080_5123, 20'h00040, 20'h77777, 1, 0);
    run_walk("leaf_fault", 32'h0080_5123, 20'h00040, 1, 20'h0, 2, 0, 0);
  endtask

  task automatic t_root_fault();   // R6
    map_page(32'h0C00_9FED, 20'h55555, 20'h33333, 0, 1);
    run_walk("root_fault", 32'h0C00_9FED, 20'h55555, 1, 20'h0, 1, 0, 0);
  endtask

  task automatic t_backpressure();   // R8 R9
    stall_en = 1; lat = 3;
    map_page(32'h1234_5678, 20'h00123, 20'h0BEEF, 1, 1);
    run_walk("stall", 32'h1234_5678, 20'h00123, 0, 20'h0BEEF, 2, 4, 0);
    stall_en = 0; lat = 0;
  endtask

  task automatic t_spurious();   // R11
    spurious = 1; stall_en = 1; lat = 2;
    map_page(32'h2345_6789, 20'h00456, 20'h0CAFE, 1, 1);
    run_walk("stray_rsp", 32'h2345_6789, 20'h00456, 0, 20'h0CAFE, 2, 0, 0);
    map_page(32'h3456_7000, 20'h00789, 20'h0D00D, 1, 0);
    run_walk("stray_rsp_fault", 32'h3456_7000, 20'h00789, 1, 20'h0, 2, 0, 0);
    spurious = 0; stall_en = 0; lat = 0;
  endtask

  task automatic t_busy_req();   // R7 with request held high
    map_page(32'h4000_1234, 20'h00999, 20'h0AAAA, 1, 1);
    run_walk("busy_req", 32'h4000_1234, 20'h00999, 0, 20'h0AAAA, 2, 2, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_basic();
    t_edges();
    t_leaf_fault();
    t_root_fault();
    t_backpressure();
    t_spurious();
    t_busy_req();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule